// File: doc/BRIEF.md
# Syscall Retire Trace Observer

This block is a passive monitor placed next to the retire port of a MIPS-style core. On every retirement it checks for a SYSCALL. When there is one, it compares the service number held in `$v1` against a parameter list of watched numbers. Each watched number owns a record:

- a seen flag;
- a saturating occurrence count;
- a snapshot taken on the first occurrence only, holding the PC, the four argument registers and the `$v0` result.

A separate record keeps the PC and service number of the first SYSCALL whose number is not in the watched list. A typical use is installing a handler: `$a0` carries a small slot index, `$a1` a function pointer, `$a2` zero and `$a3` a context pointer. The snapshot keeps those values for a later summary dump.

The `$v0` result comes from the register write-back bus. If register 2 is written in the retire cycle, that data is captured. Otherwise each record waits for the next write to register 2.

Each record runs a small state machine:

- `ST_EMPTY`: no occurrence yet.
- `ST_AWAIT_RET`: snapshot taken, `$v0` still pending.
- `ST_CAPTURED`: snapshot complete.

Its transitions are:

- `ST_EMPTY` → `ST_CAPTURED` on a hit that has a same-cycle write to register 2.
- `ST_EMPTY` → `ST_AWAIT_RET` on a hit without that write.
- `ST_AWAIT_RET` → `ST_CAPTURED` on the next write to register 2.
- Any state → `ST_EMPTY` on `clr`.

The unhandled record has its own two states:

- `ST_MISS_IDLE` → `ST_MISS_HELD` on the first unmatched SYSCALL.
- `ST_MISS_HELD` → `ST_MISS_IDLE` on `clr`.

A combinational read port returns one record, selected by index.

Top module: `sysret_observer`

## Requirements
- R1: A record changes only on a cycle where `ret_valid` and `ret_is_sys` are both 1 and `ret_v1` equals that record's watched number. A retire with either flag at 0 leaves every record unchanged.
- R2: On the first matching retire, the record sets its seen flag and its count goes to 1. It latches `ret_pc` and `ret_a0`..`ret_a3`.
- R3: Each later match increments the count and leaves the PC and argument snapshot untouched.
- R4: The occurrence count is 16 bits wide and saturates at 0xFFFF instead of wrapping.
- R5: If `wb_en` is 1 and `wb_addr` is 2 in the cycle of the first match, `wb_data` is stored as the record's `$v0`.
- R6: If there is no such write in the first-match cycle, `$v0` is taken from the next write to register 2. Writes to other registers are ignored, and once `$v0` is captured later writes do not change it.
- R7: With default parameters, read indices 0 to 5 hold service numbers 0x3C, 0x3D, 0x40, 0x64, 0x78 and 0x12 in that order.
- R8: The first SYSCALL retire whose `$v1` matches no watched number sets `unh_seen` and latches `unh_pc` and `unh_num`. Later unmatched SYSCALLs leave that record unchanged.
- R9: A 1 on `clr` at a clock edge zeroes every seen flag, count, snapshot and the unhandled record. The next match is then captured afresh.
- R10: The read port returns the record at `rd_idx` combinationally. An index at or above the number of watched entries reads as all zeros.
- R11: After reset, all records and the unhandled record read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all records |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_is_sys | input | 1 | The retiring instruction is a SYSCALL |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_v1 | input | 32 | `$v1` at retire (service number) |
| ret_a0 | input | 32 | `$a0` at retire |
| ret_a1 | input | 32 | `$a1` at retire |
| ret_a2 | input | 32 | `$a2` at retire |
| ret_a3 | input | 32 | `$a3` at retire |
| wb_en | input | 1 | Register write-back strobe |
| wb_addr | input | 5 | Write-back register number |
| wb_data | input | 32 | Write-back data |
| rd_idx | input | 3 | Record select for the read port |
| rd_seen | output | 1 | Seen flag of the selected record |
| rd_count | output | 16 | Occurrence count of the selected record |
| rd_pc | output | 32 | First-occurrence PC |
| rd_a0 | output | 32 | First-occurrence `$a0` |
| rd_a1 | output | 32 | First-occurrence `$a1` |
| rd_a2 | output | 32 | First-occurrence `$a2` |
| rd_a3 | output | 32 | First-occurrence `$a3` |
| rd_v0 | output | 32 | Captured `$v0` result |
| unh_seen | output | 1 | An unhandled SYSCALL has been recorded |
| unh_pc | output | 32 | PC of the first unhandled SYSCALL |
| unh_num | output | 32 | Service number of the first unhandled SYSCALL |

## Verification
Every record update lands at the first rising edge after the retire or write-back cycle, so the new contents are readable one cycle after the stimulus. The read port adds no delay. The driver applies each stimulus for exactly one clock, from one falling edge to the next, and pushes the expected record into the scoreboard at that second falling edge. The monitor then selects the index, waits a short settle time well before the next rising edge, and compares. The saturation run holds the retire asserted for a counted number of edges, so the expected count follows directly from that number.

// File: rtl/sysobs_pkg.sv
package sysobs_pkg;
    localparam int OBS_XLEN      = 32;
    localparam int OBS_CNT_W     = 16;
    localparam int OBS_MAX_WATCH = 8;
    localparam int OBS_IDX_W     = $clog2(OBS_MAX_WATCH);
    localparam int OBS_REG_W     = 5;
    localparam int OBS_V0_REG    = 2;

    typedef struct packed {
        logic                  seen;
        logic [OBS_CNT_W-1:0]  cnt;
        logic [OBS_XLEN-1:0]   pc;
        logic [OBS_XLEN-1:0]   a0;
        logic [OBS_XLEN-1:0]   a1;
        logic [OBS_XLEN-1:0]   a2;
        logic [OBS_XLEN-1:0]   a3;
        logic [OBS_XLEN-1:0]   v0;
    } obs_rec_t;

    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_AWAIT_RET = 2'd1,
        ST_CAPTURED  = 2'd2
    } ent_state_t;

    typedef enum logic {
        ST_MISS_IDLE = 1'b0,
        ST_MISS_HELD = 1'b1
    } miss_state_t;
endpackage

// File: rtl/sysobs_match.sv
module sysobs_match
    import sysobs_pkg::*;
#(
    parameter int                                   NUM_WATCH  = 6,
    parameter logic [OBS_MAX_WATCH*OBS_XLEN-1:0]    WATCH_LIST = '0
) (
    input  logic [OBS_XLEN-1:0]      v1,
    output logic [OBS_MAX_WATCH-1:0] match,
    output logic                     any_match
);
    for (genvar i = 0; i < OBS_MAX_WATCH; i++) begin : g_cmp
        if (i < NUM_WATCH) begin : g_live
            assign match[i] = (v1 == WATCH_LIST[i*OBS_XLEN +: OBS_XLEN]);
        end else begin : g_off
            assign match[i] = 1'b0;
        end
    end
    assign any_match = |match;
endmodule

// File: rtl/sysobs_entry.sv
module sysobs_entry
    import sysobs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 hit,
    input  logic [OBS_XLEN-1:0]  pc,
    input  logic [OBS_XLEN-1:0]  a0,
    input  logic [OBS_XLEN-1:0]  a1,
    input  logic [OBS_XLEN-1:0]  a2,
    input  logic [OBS_XLEN-1:0]  a3,
    input  logic                 wb_v0,
    input  logic [OBS_XLEN-1:0]  wb_data,
    output obs_rec_t             rec
);
    localparam logic [OBS_CNT_W-1:0] CNT_MAX = '1;

    ent_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:     if (hit) state_d = wb_v0 ? ST_CAPTURED : ST_AWAIT_RET;
            ST_AWAIT_RET: if (wb_v0) state_d = ST_CAPTURED;
            ST_CAPTURED:  state_d = ST_CAPTURED;
            default:      state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_EMPTY;
        else if (clr) state_q <= ST_EMPTY;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (clr) begin
            rec <= '0;
        end else begin
            if (hit) begin
                rec.seen <= 1'b1;
                if (rec.cnt != CNT_MAX) rec.cnt <= rec.cnt + 1'b1;
            end
            if (hit && state_q == ST_EMPTY) begin
                rec.pc <= pc;
                rec.a0 <= a0;
                rec.a1 <= a1;
                rec.a2 <= a2;
                rec.a3 <= a3;
                if (wb_v0) rec.v0 <= wb_data;
            end
            if (state_q == ST_AWAIT_RET && wb_v0) rec.v0 <= wb_data;
        end
    end

    assert_cnt_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> rec.cnt >= $past(rec.cnt));
    assert_snapshot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec.seen && !clr) |=> ($stable(rec.pc) && $stable(rec.a0) && $stable(rec.a1)
                                && $stable(rec.a2) && $stable(rec.a3)));
    assert_v0_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURED && !clr) |=> $stable(rec.v0));
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rec.seen && rec.cnt == '0));
endmodule

// File: rtl/sysobs_first_miss.sv
module sysobs_first_miss
    import sysobs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                miss,
    input  logic [OBS_XLEN-1:0] pc,
    input  logic [OBS_XLEN-1:0] num,
    output logic                held,
    output logic [OBS_XLEN-1:0] held_pc,
    output logic [OBS_XLEN-1:0] held_num
);
    miss_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MISS_IDLE: if (miss) state_d = ST_MISS_HELD;
            ST_MISS_HELD: state_d = ST_MISS_HELD;
            default:      state_d = ST_MISS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_MISS_IDLE;
        else if (clr) state_q <= ST_MISS_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_pc  <= '0;
            held_num <= '0;
        end else if (clr) begin
            held_pc  <= '0;
            held_num <= '0;
        end else if (state_q == ST_MISS_IDLE && miss) begin
            held_pc  <= pc;
            held_num <= num;
        end
    end

    assign held = (state_q == ST_MISS_HELD);

    assert_first_miss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> ($stable(held_pc) && $stable(held_num) && held));
endmodule

// File: rtl/sysret_observer.sv
module sysret_observer
    import sysobs_pkg::*;
#(
    parameter int                                NUM_WATCH  = 6,
    parameter logic [OBS_MAX_WATCH*OBS_XLEN-1:0] WATCH_LIST = {
        32'h0, 32'h0, 32'h12, 32'h78, 32'h64, 32'h40, 32'h3D, 32'h3C}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  ret_valid,
    input  logic                  ret_is_sys,
    input  logic [OBS_XLEN-1:0]   ret_pc,
    input  logic [OBS_XLEN-1:0]   ret_v1,
    input  logic [OBS_XLEN-1:0]   ret_a0,
    input  logic [OBS_XLEN-1:0]   ret_a1,
    input  logic [OBS_XLEN-1:0]   ret_a2,
    input  logic [OBS_XLEN-1:0]   ret_a3,
    input  logic                  wb_en,
    input  logic [OBS_REG_W-1:0]  wb_addr,
    input  logic [OBS_XLEN-1:0]   wb_data,
    input  logic [OBS_IDX_W-1:0]  rd_idx,
    output logic                  rd_seen,
    output logic [OBS_CNT_W-1:0]  rd_count,
    output logic [OBS_XLEN-1:0]   rd_pc,
    output logic [OBS_XLEN-1:0]   rd_a0,
    output logic [OBS_XLEN-1:0]   rd_a1,
    output logic [OBS_XLEN-1:0]   rd_a2,
    output logic [OBS_XLEN-1:0]   rd_a3,
    output logic [OBS_XLEN-1:0]   rd_v0,
    output logic                  unh_seen,
    output logic [OBS_XLEN-1:0]   unh_pc,
    output logic [OBS_XLEN-1:0]   unh_num
);
    logic                     fire;
    logic                     wb_v0;
    logic [OBS_MAX_WATCH-1:0] match;
    logic                     any_match;
    logic [OBS_MAX_WATCH-1:0] hit;
    obs_rec_t                 recs [OBS_MAX_WATCH];
    obs_rec_t                 sel;
    logic [OBS_MAX_WATCH*OBS_CNT_W-1:0] cnt_all;

    assign fire  = ret_valid && ret_is_sys;
    assign wb_v0 = wb_en && (wb_addr == OBS_REG_W'(OBS_V0_REG));

    sysobs_match #(.NUM_WATCH(NUM_WATCH), .WATCH_LIST(WATCH_LIST)) u_match (
        .v1(ret_v1), .match(match), .any_match(any_match));

    for (genvar i = 0; i < OBS_MAX_WATCH; i++) begin : g_ent
        assign hit[i] = fire && match[i];
        assign cnt_all[i*OBS_CNT_W +: OBS_CNT_W] = recs[i].cnt;
        if (i < NUM_WATCH) begin : g_live
            sysobs_entry u_entry (
                .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit[i]),
                .pc(ret_pc), .a0(ret_a0), .a1(ret_a1), .a2(ret_a2), .a3(ret_a3),
                .wb_v0(wb_v0), .wb_data(wb_data), .rec(recs[i]));
        end else begin : g_off
            assign recs[i] = '0;
        end
    end

    sysobs_first_miss u_miss (
        .clk(clk), .rst_n(rst_n), .clr(clr), .miss(fire && !any_match),
        .pc(ret_pc), .num(ret_v1),
        .held(unh_seen), .held_pc(unh_pc), .held_num(unh_num));

    assign sel      = (int'(rd_idx) < NUM_WATCH) ? recs[rd_idx] : '0;
    assign rd_seen  = sel.seen;
    assign rd_count = sel.cnt;
    assign rd_pc    = sel.pc;
    assign rd_a0    = sel.a0;
    assign rd_a1    = sel.a1;
    assign rd_a2    = sel.a2;
    assign rd_a3    = sel.a3;
    assign rd_v0    = sel.v0;

    assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_idle_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clr) |=> $stable(cnt_all));
endmodule

// File: tb/test_sysret_observer.sv
module test_sysret_observer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ret_valid = 1'b0, ret_is_sys = 1'b0;
    logic [31:0] ret_pc = '0, ret_v1 = '0, ret_a0 = '0, ret_a1 = '0, ret_a2 = '0, ret_a3 = '0;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic [2:0]  rd_idx = '0;
    logic        rd_seen, unh_seen;
    logic [15:0] rd_count;
    logic [31:0] rd_pc, rd_a0, rd_a1, rd_a2, rd_a3, rd_v0, unh_pc, unh_num;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    sysret_observer i_sysret_observer (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ret_valid(ret_valid), .ret_is_sys(ret_is_sys), .ret_pc(ret_pc), .ret_v1(ret_v1),
        .ret_a0(ret_a0), .ret_a1(ret_a1), .ret_a2(ret_a2), .ret_a3(ret_a3),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .rd_idx(rd_idx),
        .rd_seen(rd_seen), .rd_count(rd_count), .rd_pc(rd_pc), .rd_a0(rd_a0),
        .rd_a1(rd_a1), .rd_a2(rd_a2), .rd_a3(rd_a3), .rd_v0(rd_v0),
        .unh_seen(unh_seen), .unh_pc(unh_pc), .unh_num(unh_num));

    typedef struct {
        int          req;
        bit          unh;
        int          idx;
        logic        seen;
        logic [15:0] cnt;
        logic [31:0] pc, a0, a1, a2, a3, v0;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            wait (sb.size() > 0);
            if (!sb[0].unh) rd_idx = 3'(sb[0].idx);
            #1;
            if (sb[0].unh) begin
                chk(sb[0].req, "unh_seen", 32'(unh_seen), 32'(sb[0].seen));
                chk(sb[0].req, "unh_pc",   unh_pc,  sb[0].pc);
                chk(sb[0].req, "unh_num",  unh_num, sb[0].v0);
            end else begin
                chk(sb[0].req, "seen",  32'(rd_seen),  32'(sb[0].seen));
                chk(sb[0].req, "count", 32'(rd_count), 32'(sb[0].cnt));
                chk(sb[0].req, "pc", rd_pc, sb[0].pc);
                chk(sb[0].req, "a0", rd_a0, sb[0].a0);
                chk(sb[0].req, "a1", rd_a1, sb[0].a1);
                chk(sb[0].req, "a2", rd_a2, sb[0].a2);
                chk(sb[0].req, "a3", rd_a3, sb[0].a3);
                chk(sb[0].req, "v0", rd_v0, sb[0].v0);
            end
            void'(sb.pop_front());
        end
    end

    task automatic exp_entry(input int req, input int idx, input logic seen, input logic [15:0] cnt,
                             input logic [31:0] pc, a0, a1, a2, a3, v0);
        exp_t e;
        e.req = req; e.unh = 1'b0; e.idx = idx; e.seen = seen; e.cnt = cnt;
        e.pc = pc; e.a0 = a0; e.a1 = a1; e.a2 = a2; e.a3 = a3; e.v0 = v0;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic exp_unh(input int req, input logic seen, input logic [31:0] pc, input logic [31:0] num);
        exp_t e;
        e.req = req; e.unh = 1'b1; e.idx = 0; e.seen = seen; e.cnt = '0;
        e.pc = pc; e.a0 = '0; e.a1 = '0; e.a2 = '0; e.a3 = '0; e.v0 = num;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    // one-cycle retire, optionally with a write-back in the same cycle
    task automatic retire(input logic valid, input logic sys, input logic [31:0] pc, v1, a0, a1, a2, a3,
                          input logic wbe, input logic [4:0] wba, input logic [31:0] wbd);
        @(negedge clk);
        ret_valid = valid; ret_is_sys = sys; ret_pc = pc; ret_v1 = v1;
        ret_a0 = a0; ret_a1 = a1; ret_a2 = a2; ret_a3 = a3;
        wb_en = wbe; wb_addr = wba; wb_data = wbd;
        @(negedge clk);
        ret_valid = 1'b0; ret_is_sys = 1'b0; wb_en = 1'b0;
    endtask

    task automatic writeback(input logic [4:0] wba, input logic [31:0] wbd);
        retire(1'b0, 1'b0, '0, '0, '0, '0, '0, '0, 1'b1, wba, wbd);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        exp_entry(11, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        exp_entry(11, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        exp_unh(11, 0, 0, 0);

        // R2 R5 R7: first 0x12 with handler-install args and same-cycle $v0
        retire(1, 1, 32'h0011_2A54, 32'h12, 32'h5, 32'h0011_2AB0, 32'h0, 32'h0013_28C0, 1, 5'd2, 32'hAA);
        exp_entry(2, 5, 1, 1, 32'h0011_2A54, 32'h5, 32'h0011_2AB0, 0, 32'h0013_28C0, 32'hAA);
        exp_entry(7, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R1: non-SYSCALL retire and SYSCALL without valid leave the record alone
        retire(1, 0, 32'h500, 32'h12, 1, 1, 1, 1, 0, 5'd0, 0);
        retire(0, 1, 32'h504, 32'h12, 1, 1, 1, 1, 0, 5'd0, 0);
        exp_entry(1, 5, 1, 1, 32'h0011_2A54, 32'h5, 32'h0011_2AB0, 0, 32'h0013_28C0, 32'hAA);
        exp_unh(1, 0, 0, 0);

        // R3: second match counts, snapshot and $v0 untouched
        retire(1, 1, 32'h600, 32'h12, 9, 9, 9, 9, 1, 5'd2, 32'h55);
        exp_entry(3, 5, 1, 2, 32'h0011_2A54, 32'h5, 32'h0011_2AB0, 0, 32'h0013_28C0, 32'hAA);

        // R6: 0x78 (index 4) without write-back, then deferred $v0
        retire(1, 1, 32'h400, 32'h78, 1, 2, 3, 4, 0, 5'd0, 0);
        exp_entry(6, 4, 1, 1, 32'h400, 1, 2, 3, 4, 0);
        writeback(5'd3, 32'h99);
        exp_entry(6, 4, 1, 1, 32'h400, 1, 2, 3, 4, 0);
        writeback(5'd2, 32'h77);
        exp_entry(6, 4, 1, 1, 32'h400, 1, 2, 3, 4, 32'h77);
        writeback(5'd2, 32'h11);
        exp_entry(6, 4, 1, 1, 32'h400, 1, 2, 3, 4, 32'h77);

        // R7: 0x40 lands in index 2, 0x64 in index 3
        retire(1, 1, 32'h700, 32'h40, 7, 0, 0, 0, 1, 5'd2, 32'h1);
        exp_entry(7, 2, 1, 1, 32'h700, 7, 0, 0, 0, 32'h1);
        retire(1, 1, 32'h710, 32'h64, 8, 0, 0, 0, 1, 5'd2, 32'h2);
        exp_entry(7, 3, 1, 1, 32'h710, 8, 0, 0, 0, 32'h2);

        // R8: first unhandled kept, second ignored
        retire(1, 1, 32'h0011_2A74, 32'h16, 5, 0, 0, 0, 0, 5'd0, 0);
        exp_unh(8, 1, 32'h0011_2A74, 32'h16);
        retire(1, 1, 32'h800, 32'h20, 0, 0, 0, 0, 0, 5'd0, 0);
        exp_unh(8, 1, 32'h0011_2A74, 32'h16);

        // R10: indices past the watched set read zero
        exp_entry(10, 6, 0, 0, 0, 0, 0, 0, 0, 0);
        exp_entry(10, 7, 0, 0, 0, 0, 0, 0, 0, 0);

        // R4: saturate 0x3D (index 1) with 65540 back-to-back matches
        @(negedge clk);
        ret_valid = 1; ret_is_sys = 1; ret_pc = 32'h900; ret_v1 = 32'h3D;
        ret_a0 = 32'hA; ret_a1 = 32'hB; ret_a2 = 32'hC; ret_a3 = 32'hD;
        repeat (65540) @(negedge clk);
        ret_valid = 0; ret_is_sys = 0;
        exp_entry(4, 1, 1, 16'hFFFF, 32'h900, 32'hA, 32'hB, 32'hC, 32'hD, 0);

        // R9: clear wipes all, then fresh capture
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_entry(9, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        exp_entry(9, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        exp_unh(9, 0, 0, 0);
        retire(1, 1, 32'hA00, 32'h12, 3, 4, 5, 6, 1, 5'd2, 32'h33);
        exp_entry(9, 5, 1, 1, 32'hA00, 3, 4, 5, 6, 32'h33);
        exp_entry(5, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        summary();
        $finish;
    end
endmodule